// File: doc/BRIEF.md
# Debug Trace Capture Unit

This block records an execution trace into a circular buffer of 64 lines while a debug session is armed. Each cycle it may receive one record from the core: a valid flag, a change-of-flow flag, a memory-access flag, an address, a data word and a program counter. A configuration write port sets three fields: trace enable, capture mode and trigger alignment. The capture mode picks which records become buffer lines and how each line is packed. The alignment picks whether the trigger pulse ends the capture or starts it.

A line counter reports how many lines the current session has stored. Its top bit is a buffer-full flag that survives every reset except power-on. Software reads lines through a combinational read port, which gives data only while trace is enabled. A secure-mode input blocks tracing and stops trace from being enabled. Arm and disarm strobes start and end a session.

Top module: `trace_capture`

## Requirements
- R1: After power-on reset `armed` is 0, `lineCount` is 0 and `cfgEnable`, `cfgMode` and `cfgAlign` are 0.
- R2: `lineCount` is {full flag, line count}. The line count goes up by one for each stored line and stops at 64. The full flag sets on the store that brings the count to 64.
- R3: An arm strobe clears the count and the full flag. A pulse on `sysRstN` clears the count, `armed` and the configuration fields but leaves the full flag as it was. Only `porRstN` clears the full flag.
- R4: A configuration write changes `cfgEnable` only while `secureIn` is 0 and the unit is disarmed. It changes `cfgMode` and `cfgAlign` only while the unit is disarmed.
- R5: While `secureIn` is 1, no record is stored. While `cfgEnable` is 0, `rdData` reads 0.
- R6: In mode 00, a valid record with `recCof`=1 is stored as the line {recAddr, recPc}. Records with `recCof`=0 are skipped.
- R7: Mode 01 works like mode 00, except that a record whose `recAddr` equals the address of the most recently stored line of the session is not stored.
- R8: In mode 10, a valid record with `recMem`=1 is stored as the line {recAddr, recData}.
- R9: In mode 11, every valid record is stored as the line {16'h0, recPc}.
- R10: With alignment 0, capture runs from arming. The write position wraps from slot 63 back to slot 0, so store number n lands in slot n mod 64. A trigger disarms the unit, and the record in the trigger cycle is not stored.
- R11: With alignment 1, no record is stored before the trigger. The record in the trigger cycle goes into slot 0. The session ends by itself after the 64th store.
- R12: An arm strobe sets `armed` in the next cycle and restarts the session. A disarm strobe clears `armed`, and it takes priority when both strobes arrive in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, synchronous, active low |
| sysRstN | input | 1 | System reset, synchronous, active low; does not clear the full flag |
| secureIn | input | 1 | Device secured |
| armSet | input | 1 | Arm strobe |
| armClr | input | 1 | Disarm strobe |
| trigIn | input | 1 | Trigger pulse |
| recValid | input | 1 | Record valid this cycle |
| recCof | input | 1 | Record is a change of flow |
| recMem | input | 1 | Record is a memory or register access |
| recAddr | input | 16 | Record address |
| recData | input | 16 | Record data |
| recPc | input | 16 | Program counter of the record |
| cfgWe | input | 1 | Configuration write strobe |
| cfgEnableWr | input | 1 | Trace enable value to write |
| cfgModeWr | input | 2 | Capture mode value to write |
| cfgAlignWr | input | 1 | Trigger alignment value to write |
| cfgEnable | output | 1 | Current trace enable |
| cfgMode | output | 2 | Current capture mode |
| cfgAlign | output | 1 | Current trigger alignment |
| armed | output | 1 | Session armed |
| lineCount | output | 8 | {full flag, stored line count} |
| rdAddr | input | 6 | Buffer read slot |
| rdData | output | 32 | Buffer line at rdAddr, or 0 when trace is disabled |

## Verification
The assertions assume that the trigger, the arm strobes and the configuration write are single-cycle pulses, and that the record fields are sampled only when `recValid` is high. They assume no fixed relation between the secure input and the session state, so the secure-lock checks hold even if secure mode is entered in mid-session. The stimulus drives every strobe for exactly one cycle on the falling edge and changes `secureIn` only while the unit is disarmed. It also keeps the record fields stable for the whole cycle in which they are valid.

// File: rtl/trace_pkg.sv
package trace_pkg;

  typedef enum logic [1:0] {
    MODE_FLOW   = 2'b00,
    MODE_LOOP   = 2'b01,
    MODE_DETAIL = 2'b10,
    MODE_PCONLY = 2'b11
  } traceMode_t;

  typedef struct packed {
    logic store;
    logic clear;
  } capStrobe_t;

endpackage

// File: rtl/trace_ctrl.sv
module trace_ctrl
  import trace_pkg::*;
#(
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             porRstN,
  input  logic             sysRstN,
  input  logic             secureIn,
  input  logic             armSet,
  input  logic             armClr,
  input  logic             trigIn,
  input  logic             recValid,
  input  logic             recCof,
  input  logic             recMem,
  input  logic [W-1:0]     recAddr,
  input  logic [W-1:0]     recData,
  input  logic [W-1:0]     recPc,
  input  logic             cfgWe,
  input  logic             cfgEnableWr,
  input  logic [1:0]       cfgModeWr,
  input  logic             cfgAlignWr,
  input  logic             lastSlot,
  output capStrobe_t       stb,
  output logic [2*W-1:0]   lineOut,
  output logic             cfgEnable,
  output logic [1:0]       cfgMode,
  output logic             cfgAlign,
  output logic             armed
);

  traceMode_t    modeQ;
  logic          started;
  logic          lastValid;
  logic [W-1:0]  lastAddr;
  logic          sessionGate;
  logic          recWanted;
  logic          doStore;
  logic          doClear;
  logic          endByTrig;
  logic          endByFull;
  logic          anyRst;

  assign anyRst = !porRstN || !sysRstN;

  // Configuration fields with their write locks
  always_ff @(posedge clk) begin
    if (anyRst) begin
      cfgEnable <= 1'b0;
      modeQ     <= MODE_FLOW;
      cfgAlign  <= 1'b0;
    end else if (cfgWe && !armed) begin
      modeQ    <= traceMode_t'(cfgModeWr);
      cfgAlign <= cfgAlignWr;
      if (!secureIn) cfgEnable <= cfgEnableWr;
    end
  end

  assign cfgMode = modeQ;

  // Session window
  always_comb begin
    if (cfgAlign) sessionGate = started || trigIn;
    else          sessionGate = !trigIn;
  end

  // Record qualification by capture mode
  always_comb begin
    recWanted = 1'b0;
    lineOut   = '0;
    unique case (modeQ)
      MODE_FLOW: begin
        recWanted = recValid && recCof;
        lineOut   = {recAddr, recPc};
      end
      MODE_LOOP: begin
        recWanted = recValid && recCof && !(lastValid && (recAddr == lastAddr));
        lineOut   = {recAddr, recPc};
      end
      MODE_DETAIL: begin
        recWanted = recValid && recMem;
        lineOut   = {recAddr, recData};
      end
      MODE_PCONLY: begin
        recWanted = recValid;
        lineOut   = {{W{1'b0}}, recPc};
      end
      default: begin
        recWanted = 1'b0;
        lineOut   = '0;
      end
    endcase
  end

  assign doClear   = armSet && !armClr;
  assign doStore   = armed && cfgEnable && !secureIn && !armClr && !armSet
                     && sessionGate && recWanted;
  assign endByTrig = armed && !cfgAlign && trigIn;
  assign endByFull = armed && cfgAlign && doStore && lastSlot;

  assign stb.store = doStore;
  assign stb.clear = doClear;

  // Arm state, post-trigger flag and last stored address
  always_ff @(posedge clk) begin
    if (anyRst) begin
      armed     <= 1'b0;
      started   <= 1'b0;
      lastValid <= 1'b0;
      lastAddr  <= '0;
    end else begin
      if (armClr)                      armed <= 1'b0;
      else if (armSet)                 armed <= 1'b1;
      else if (endByTrig || endByFull) armed <= 1'b0;

      if (doClear || armClr)                  started <= 1'b0;
      else if (armed && cfgAlign && trigIn)   started <= 1'b1;

      if (doClear) begin
        lastValid <= 1'b0;
      end else if (doStore) begin
        lastValid <= 1'b1;
        lastAddr  <= recAddr;
      end
    end
  end

  p_enable_lock_r4: assert property (@(posedge clk) disable iff (anyRst)
    (secureIn || armed) |=> $stable(cfgEnable));

  p_field_lock_r4: assert property (@(posedge clk) disable iff (anyRst)
    armed |=> ($stable(cfgMode) && $stable(cfgAlign)));

  p_secure_nostore_r5: assert property (@(posedge clk) disable iff (anyRst)
    secureIn |-> !stb.store);

  p_arm_rise_r12: assert property (@(posedge clk) disable iff (anyRst)
    $rose(armed) |-> $past(armSet && !armClr));

  p_disarm_wins_r12: assert property (@(posedge clk) disable iff (anyRst)
    armClr |=> !armed);

  p_trig_stops_r10: assert property (@(posedge clk) disable iff (anyRst)
    (armed && !cfgAlign && trigIn) |-> !stb.store);

endmodule

// File: rtl/trace_store.sv
module trace_store
  import trace_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 64,
  localparam int LINE_W = 2 * W,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              sysRstN,
  input  capStrobe_t        stb,
  input  logic [LINE_W-1:0] lineIn,
  input  logic              readEn,
  input  logic [PTR_W-1:0]  rdAddr,
  output logic              lastSlot,
  output logic [CNT_W:0]    lineCount,
  output logic [LINE_W-1:0] rdData
);

  logic [LINE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  wrPtrNext;
  logic [CNT_W-1:0]  count;
  logic              full;
  logic              anyRst;

  assign anyRst = !porRstN || !sysRstN;

  generate
    if ((1 << PTR_W) == DEPTH) begin : g_pow2_wrap
      assign wrPtrNext = wrPtr + 1'b1;
    end else begin : g_cmp_wrap
      assign wrPtrNext = (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
    end
  endgenerate

  assign lastSlot = (count == CNT_W'(DEPTH - 1));

  always_ff @(posedge clk) begin
    if (stb.store) mem[wrPtr] <= lineIn;
  end

  always_ff @(posedge clk) begin
    if (anyRst) begin
      wrPtr <= '0;
      count <= '0;
    end else if (stb.clear) begin
      wrPtr <= '0;
      count <= '0;
    end else if (stb.store) begin
      wrPtr <= wrPtrNext;
      if (count != CNT_W'(DEPTH)) count <= count + 1'b1;
    end
  end

  // Full flag: power-on reset only
  always_ff @(posedge clk) begin
    if (!porRstN)                     full <= 1'b0;
    else if (!sysRstN)                full <= full;
    else if (stb.clear)               full <= 1'b0;
    else if (stb.store && lastSlot)   full <= 1'b1;
  end

  assign lineCount = {full, count};
  assign rdData    = readEn ? mem[rdAddr] : '0;

  p_count_sat_r2: assert property (@(posedge clk) disable iff (anyRst)
    count <= CNT_W'(DEPTH));

  p_full_at_top_r2: assert property (@(posedge clk) disable iff (anyRst)
    (count == CNT_W'(DEPTH)) |-> full);

  p_full_keeps_r3: assert property (@(posedge clk) disable iff (!porRstN)
    (full && !stb.clear) |=> full);

  p_clear_empties_r3: assert property (@(posedge clk) disable iff (anyRst)
    stb.clear |=> (lineCount == '0));

endmodule

// File: rtl/trace_capture.sv
module trace_capture
  import trace_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 64,
  localparam int LINE_W = 2 * W,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              sysRstN,
  input  logic              secureIn,
  input  logic              armSet,
  input  logic              armClr,
  input  logic              trigIn,
  input  logic              recValid,
  input  logic              recCof,
  input  logic              recMem,
  input  logic [W-1:0]      recAddr,
  input  logic [W-1:0]      recData,
  input  logic [W-1:0]      recPc,
  input  logic              cfgWe,
  input  logic              cfgEnableWr,
  input  logic [1:0]        cfgModeWr,
  input  logic              cfgAlignWr,
  output logic              cfgEnable,
  output logic [1:0]        cfgMode,
  output logic              cfgAlign,
  output logic              armed,
  output logic [CNT_W:0]    lineCount,
  input  logic [PTR_W-1:0]  rdAddr,
  output logic [LINE_W-1:0] rdData
);

  capStrobe_t        stb;
  logic [LINE_W-1:0] line;
  logic              lastSlot;

  trace_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN), .secureIn(secureIn),
    .armSet(armSet), .armClr(armClr), .trigIn(trigIn),
    .recValid(recValid), .recCof(recCof), .recMem(recMem),
    .recAddr(recAddr), .recData(recData), .recPc(recPc),
    .cfgWe(cfgWe), .cfgEnableWr(cfgEnableWr), .cfgModeWr(cfgModeWr),
    .cfgAlignWr(cfgAlignWr), .lastSlot(lastSlot),
    .stb(stb), .lineOut(line),
    .cfgEnable(cfgEnable), .cfgMode(cfgMode), .cfgAlign(cfgAlign),
    .armed(armed)
  );

  trace_store #(.W(W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN),
    .stb(stb), .lineIn(line), .readEn(cfgEnable), .rdAddr(rdAddr),
    .lastSlot(lastSlot), .lineCount(lineCount), .rdData(rdData)
  );

endmodule

// File: tb/sim_trace_capture.sv
module sim_trace_capture;

  logic        clk = 1'b0;
  logic        porRstN = 1'b0, sysRstN = 1'b0;
  logic        secureIn = 1'b0, armSet = 1'b0, armClr = 1'b0, trigIn = 1'b0;
  logic        recValid = 1'b0, recCof = 1'b0, recMem = 1'b0;
  logic [15:0] recAddr = '0, recData = '0, recPc = '0;
  logic        cfgWe = 1'b0, cfgEnableWr = 1'b0, cfgAlignWr = 1'b0;
  logic [1:0]  cfgModeWr = '0;
  logic        cfgEnable, cfgAlign, armed;
  logic [1:0]  cfgMode;
  logic [7:0]  lineCount;
  logic [5:0]  rdAddr = '0;
  logic [31:0] rdData;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] expQ [$];

  always #5 clk = ~clk;

  trace_capture u0 (.*);

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeCfg(bit en, bit [1:0] md, bit al);
    cfgWe = 1'b1; cfgEnableWr = en; cfgModeWr = md; cfgAlignWr = al;
    step();
    cfgWe = 1'b0;
  endtask

  task automatic doArm();
    armSet = 1'b1; step(); armSet = 1'b0;
  endtask

  task automatic doDisarm();
    armClr = 1'b1; step(); armClr = 1'b0;
  endtask

  task automatic sendRec(bit cof, bit mem, logic [15:0] a, logic [15:0] d,
                         logic [15:0] pc, bit trig);
    recValid = 1'b1; recCof = cof; recMem = mem;
    recAddr = a; recData = d; recPc = pc; trigIn = trig;
    step();
    recValid = 1'b0; trigIn = 1'b0;
  endtask

  task automatic pushExp(logic [31:0] v);
    expQ.push_back(v);
  endtask

  // Monitor side of the scoreboard: read slots in order, pop and compare
  task automatic drainBuf(string req);
    int slot = 0;
    while (expQ.size() > 0) begin
      logic [31:0] e;
      e = expQ.pop_front();
      rdAddr = 6'(slot);
      #1;
      check(req, rdData, e);
      slot++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    step(); step();
    porRstN = 1'b1; sysRstN = 1'b1;
    step();
    // R1 reset state
    check("R1 armed", 32'(armed), 32'd0);
    check("R1 lineCount", 32'(lineCount), 32'd0);
    check("R1 cfg", 32'({cfgEnable, cfgMode, cfgAlign}), 32'd0);

    // R12 arm and disarm in the same cycle: disarm wins
    armSet = 1'b1; armClr = 1'b1; step(); armSet = 1'b0; armClr = 1'b0;
    check("R12 disarm priority", 32'(armed), 32'd0);

    // R6 mode 00 change-of-flow capture
    writeCfg(1'b1, 2'b00, 1'b0);
    doArm();
    check("R12 armed after strobe", 32'(armed), 32'd1);
    sendRec(1, 0, 16'h1000, 16'hAAAA, 16'h0100, 0); pushExp(32'h1000_0100);
    sendRec(0, 1, 16'h1002, 16'hBBBB, 16'h0102, 0);
    sendRec(1, 0, 16'h2000, 16'hCCCC, 16'h0200, 0); pushExp(32'h2000_0200);
    sendRec(0, 0, 16'h2002, 16'hDDDD, 16'h0202, 0);
    sendRec(1, 0, 16'h3000, 16'hEEEE, 16'h0300, 0); pushExp(32'h3000_0300);
    // R4 writes locked while armed
    writeCfg(1'b0, 2'b11, 1'b1);
    check("R4 enable locked when armed", 32'(cfgEnable), 32'd1);
    check("R4 mode/align locked when armed", 32'({cfgMode, cfgAlign}), 32'd0);
    doDisarm();
    check("R12 disarmed", 32'(armed), 32'd0);
    check("R6 count", 32'(lineCount), 32'd3);
    drainBuf("R6 line");

    // R7 mode 01 suppresses repeats of last stored address
    writeCfg(1'b1, 2'b01, 1'b0);
    doArm();
    check("R3 arm clears count", 32'(lineCount), 32'd0);
    sendRec(1, 0, 16'h4000, 0, 16'h0010, 0); pushExp(32'h4000_0010);
    sendRec(1, 0, 16'h4000, 0, 16'h0020, 0);
    sendRec(1, 0, 16'h5000, 0, 16'h0030, 0); pushExp(32'h5000_0030);
    sendRec(1, 0, 16'h5000, 0, 16'h0040, 0);
    sendRec(1, 0, 16'h4000, 0, 16'h0050, 0); pushExp(32'h4000_0050);
    doDisarm();
    check("R7 count", 32'(lineCount), 32'd3);
    drainBuf("R7 line");

    // R8 mode 10 memory accesses
    writeCfg(1'b1, 2'b10, 1'b0);
    doArm();
    sendRec(0, 1, 16'h6000, 16'h1111, 16'h0001, 0); pushExp(32'h6000_1111);
    sendRec(1, 0, 16'h6100, 16'h2222, 16'h0002, 0);
    sendRec(1, 1, 16'h6200, 16'h3333, 16'h0003, 0); pushExp(32'h6200_3333);
    doDisarm();
    check("R8 count", 32'(lineCount), 32'd2);
    drainBuf("R8 line");

    // R9 mode 11 every instruction
    writeCfg(1'b1, 2'b11, 1'b0);
    doArm();
    sendRec(0, 0, 16'h7000, 16'h9999, 16'h0A00, 0); pushExp(32'h0000_0A00);
    sendRec(1, 1, 16'h7100, 16'h8888, 16'h0A02, 0); pushExp(32'h0000_0A02);
    doDisarm();
    check("R9 count", 32'(lineCount), 32'd2);
    drainBuf("R9 line");

    // R10 / R2 wrap with alignment 0, trigger freezes
    doArm();
    for (int j = 0; j < 70; j++) sendRec(0, 0, 0, 0, 16'(j), 0);
    check("R2 full and saturated", 32'(lineCount), 32'h0000_00C0);
    check("R10 still armed before trigger", 32'(armed), 32'd1);
    for (int k = 0; k < 64; k++) pushExp(32'((k < 6) ? 64 + k : k));
    drainBuf("R10 wrapped line");
    sendRec(0, 0, 0, 0, 16'd999, 1);
    check("R10 trigger disarms", 32'(armed), 32'd0);
    rdAddr = 6'd6; #1;
    check("R10 trigger record not stored", rdData, 32'd6);
    check("R10 count unchanged", 32'(lineCount), 32'h0000_00C0);

    // R3 system reset keeps full flag
    sysRstN = 1'b0; step(); sysRstN = 1'b1;
    check("R3 sysRst keeps full", 32'(lineCount), 32'h0000_0080);
    check("R3 sysRst clears cfg", 32'({cfgEnable, cfgMode, cfgAlign}), 32'd0);
    writeCfg(1'b1, 2'b11, 1'b1);
    doArm();
    check("R3 arm clears full", 32'(lineCount), 32'd0);

    // R11 alignment 1: capture begins at trigger, stops after 64 stores
    for (int j = 0; j < 5; j++) sendRec(0, 0, 0, 0, 16'hF000 + 16'(j), 0);
    check("R11 nothing before trigger", 32'(lineCount), 32'd0);
    sendRec(0, 0, 0, 0, 16'd100, 1);
    for (int j = 1; j < 64; j++) sendRec(0, 0, 0, 0, 16'(100 + j), 0);
    check("R11 self disarm at full", 32'(armed), 32'd0);
    sendRec(0, 0, 0, 0, 16'd999, 0);
    check("R11 count after end", 32'(lineCount), 32'h0000_00C0);
    rdAddr = 6'd0; #1; check("R11 first line", rdData, 32'd100);
    rdAddr = 6'd63; #1; check("R11 last line", rdData, 32'd163);

    // R3 power-on reset clears full
    porRstN = 1'b0; step(); porRstN = 1'b1; step();
    check("R3 por clears full", 32'(lineCount), 32'd0);

    // R4 / R5 secure mode
    writeCfg(1'b1, 2'b11, 1'b0);
    secureIn = 1'b1; step();
    writeCfg(1'b0, 2'b11, 1'b0);
    check("R4 enable locked when secure", 32'(cfgEnable), 32'd1);
    doArm();
    for (int j = 0; j < 3; j++) sendRec(1, 1, 0, 0, 16'h0055, 0);
    check("R5 no store while secure", 32'(lineCount), 32'd0);
    doDisarm();
    secureIn = 1'b0; step();
    writeCfg(1'b0, 2'b11, 1'b0);
    check("R4 enable writable when open", 32'(cfgEnable), 32'd0);
    rdAddr = 6'd0; #1;
    check("R5 read gated by enable", rdData, 32'd0);
    writeCfg(1'b1, 2'b11, 1'b0);
    #1;
    check("R5 read returns line when enabled", rdData, 32'd100);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule